// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor's power-conservation level using sideband signals from the chipset. It runs on a free-running control clock. Three asynchronous inputs drive it: a sleep request, an indication that the core's reference clock is running, and an active-low request for the deepest sleep level. From these it keeps one of four levels: Running, Sleep, Deep Sleep and Deeper Sleep. It publishes that level as a 2-bit code. It also drives an active-low power-status flag and a request for the voltage regulator to lower core voltage.

Sleep is the hub state. From Sleep the controller can drop to Deep Sleep when the reference clock stops, or to Deeper Sleep when the dedicated request pin is pulled low. It can also return to Running when the sleep request goes away. Both deep levels come back only through Sleep.

The block models no clock gating, PLL or voltage level. It only sequences the levels and drives the indicator outputs. Every input passes through a synchronizer before the state logic sees it.

Top module: `lps_ctrl`

## Requirements
- R1: The level code is 00 Running, 01 Sleep, 10 Deep Sleep, 11 Deeper Sleep. While reset is low, and after it rises, the code is 00, `pwr_stat_n_o` is 1 and `vreg_low_o` is 0.
- R2: From Running, a high sleep request moves the level to Sleep. From Sleep, a low sleep request returns it to Running, provided the reference clock runs and no deeper request is present.
- R3: From Sleep, a stopped reference clock (`refclk_run_i` low) with no deeper request moves the level to Deep Sleep. Deep Sleep returns to Sleep only when the clock runs again, and it ignores both the sleep request and the deeper request.
- R4: From Sleep, a low `deeper_n_i` moves the level to Deeper Sleep. This request takes priority over a stopped clock and over a dropped sleep request. A high `deeper_n_i` returns Deeper Sleep to Sleep.
- R5: In Deeper Sleep the reference clock and the sleep request have no effect, and no level other than Sleep follows it.
- R6: `pwr_stat_n_o` is 0 exactly while the level is Deep Sleep or Deeper Sleep. It is 1 in every other level.
- R7: `vreg_low_o` is 1 exactly while the level is Deeper Sleep.
- R8: In Running, a stopped clock or a low deeper request has no effect. Only the sleep request leaves Running.
- R9: An input change reaches the level code on the (SYNC_STAGES+1)-th rising clock edge after the change. With the default of 2 stages, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, high = sleep |
| refclk_run_i | input | 1 | Asynchronous indication that the core reference clock runs |
| deeper_n_i | input | 1 | Asynchronous deeper-sleep request, active low |
| state_o | output | 2 | Current level code |
| pwr_stat_n_o | output | 1 | Power-status flag, low in both deep levels |
| vreg_low_o | output | 1 | Request to the regulator to lower core voltage |

## Verification
Some rules are checked by assertions on every cycle against the synchronized inputs. These are that Deeper Sleep only holds or returns to Sleep, and that Running and Deep Sleep hold until their own exit input appears. They also cover that a deeper request in Sleep always wins the next step, and that the two indicator outputs agree with the level code. Only the bench's scenarios can show some other behaviour. That includes the exact synchronizer latency and the reset values. It also includes a chained walk through Sleep when several inputs change at once, such as Deeper to Sleep to Deep. The last is that ignored inputs leave the published level unchanged across long waits.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_DEEP   = 2'b10,
        ST_DEEPER = 2'b11
    } lps_state_e;

    typedef struct packed {
        lps_state_e st;
        logic       pstat_n;
        logic       vlow;
    } lps_regs_t;

    localparam int unsigned N_SIDEBAND = 3;
    localparam int unsigned IDX_SLEEP  = 0;
    localparam int unsigned IDX_CLKRUN = 1;
    localparam int unsigned IDX_DEEPN  = 2;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int unsigned       WIDTH   = 3,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_s,
    input  logic       clkrun_s,
    input  logic       deeper_n_s,
    output logic [1:0] state_o,
    output logic       pstat_n_o,
    output logic       vlow_o
);
    lps_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (slp_s) r_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (!deeper_n_s)    r_d.st = ST_DEEPER;
                else if (!clkrun_s) r_d.st = ST_DEEP;
                else if (!slp_s)    r_d.st = ST_RUN;
            end
            ST_DEEP: begin
                if (clkrun_s) r_d.st = ST_SLEEP;
            end
            ST_DEEPER: begin
                if (deeper_n_s) r_d.st = ST_SLEEP;
            end
            default: r_d.st = ST_RUN;
        endcase
        r_d.pstat_n = !((r_d.st == ST_DEEP) || (r_d.st == ST_DEEPER));
        r_d.vlow    = (r_d.st == ST_DEEPER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_RUN;
            r_q.pstat_n <= 1'b1;
            r_q.vlow    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.st;
    assign pstat_n_o = r_q.pstat_n;
    assign vlow_o    = r_q.vlow;
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req_i,
    input  logic       refclk_run_i,
    input  logic       deeper_n_i,
    output logic [1:0] state_o,
    output logic       pwr_stat_n_o,
    output logic       vreg_low_o
);
    localparam logic [N_SIDEBAND-1:0] SYNC_RST = 3'b110; // deeper_n=1, clkrun=1, sleep=0

    logic [N_SIDEBAND-1:0] raw_in;
    logic [N_SIDEBAND-1:0] sync_in;
    logic                  slp_s, clkrun_s, deeper_n_s;

    assign raw_in[IDX_SLEEP]  = sleep_req_i;
    assign raw_in[IDX_CLKRUN] = refclk_run_i;
    assign raw_in[IDX_DEEPN]  = deeper_n_i;

    // R9: every sideband input is synchronized before use
    lps_sync #(
        .WIDTH  (N_SIDEBAND),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_in)
    );

    assign slp_s      = sync_in[IDX_SLEEP];
    assign clkrun_s   = sync_in[IDX_CLKRUN];
    assign deeper_n_s = sync_in[IDX_DEEPN];

    lps_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slp_s     (slp_s),
        .clkrun_s  (clkrun_s),
        .deeper_n_s(deeper_n_s),
        .state_o   (state_o),
        .pstat_n_o (pwr_stat_n_o),
        .vlow_o    (vreg_low_o)
    );
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slp_s,
    input logic       clkrun_s,
    input logic       deeper_n_s,
    input logic [1:0] state_o,
    input logic       pwr_stat_n_o,
    input logic       vreg_low_o
);
    // R5: Deeper Sleep only holds or returns to Sleep
    p_deeper_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11) |=> (state_o == 2'b11 || state_o == 2'b01));

    // R4: deeper request in Sleep wins the next step
    p_sleep_to_deeper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && !deeper_n_s) |=> (state_o == 2'b11));

    // R4: released request leaves Deeper Sleep
    p_deeper_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && deeper_n_s) |=> (state_o == 2'b01));

    // R3: Deep Sleep holds while the clock stays stopped
    p_deep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && !clkrun_s) |=> (state_o == 2'b10));

    // R8: Running holds without a sleep request
    p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && !slp_s) |=> (state_o == 2'b00));

    // R6: power-status low exactly in the deep levels
    p_pstat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_stat_n_o == !state_o[1]);

    // R7: voltage-lower request exactly in Deeper Sleep
    p_vlow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_low_o == (state_o == 2'b11));
endmodule

bind lps_ctrl lps_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slp_s       (slp_s),
    .clkrun_s    (clkrun_s),
    .deeper_n_s  (deeper_n_s),
    .state_o     (state_o),
    .pwr_stat_n_o(pwr_stat_n_o),
    .vreg_low_o  (vreg_low_o)
);

// File: tb/lps_ctrl_test.sv
`timescale 1ns/1ps
module lps_ctrl_test;
    localparam int unsigned STG    = 2;
    localparam int unsigned LAT    = STG + 1;
    localparam int unsigned SETTLE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       refclk_run = 1'b1;
    logic       deeper_n = 1'b1;
    logic [1:0] state;
    logic       pstat_n;
    logic       vlow;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lps_ctrl #(.SYNC_STAGES(STG)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_req),
        .refclk_run_i(refclk_run),
        .deeper_n_i  (deeper_n),
        .state_o     (state),
        .pwr_stat_n_o(pstat_n),
        .vreg_low_o  (vlow)
    );

    // row: [10:7] requirement number, [6] sleep, [5] clkrun, [4] deeper_n,
    //      [3:2] expected level, [1] expected pstat_n, [0] expected vlow
    localparam logic [10:0] VEC [12] = '{
        {4'd2, 3'b111, 2'b01, 1'b1, 1'b0},  // R2 run -> sleep
        {4'd3, 3'b101, 2'b10, 1'b0, 1'b0},  // R3 clock stops -> deep
        {4'd3, 3'b001, 2'b10, 1'b0, 1'b0},  // R3 sleep drop ignored in deep
        {4'd3, 3'b000, 2'b10, 1'b0, 1'b0},  // R3 deeper request ignored in deep
        {4'd4, 3'b110, 2'b11, 1'b0, 1'b1},  // R4 deep -> sleep -> deeper, R7
        {4'd5, 3'b000, 2'b11, 1'b0, 1'b1},  // R5 clock and sleep ignored
        {4'd2, 3'b011, 2'b00, 1'b1, 1'b0},  // R2 deeper -> sleep -> run
        {4'd8, 3'b000, 2'b00, 1'b1, 1'b0},  // R8 run ignores clock and deeper
        {4'd4, 3'b100, 2'b11, 1'b0, 1'b1},  // R4 deeper beats stopped clock
        {4'd3, 3'b101, 2'b10, 1'b0, 1'b0},  // R3 deeper -> sleep -> deep
        {4'd6, 3'b111, 2'b01, 1'b1, 1'b0},  // R6 pstat released on deep exit
        {4'd2, 3'b011, 2'b00, 1'b1, 1'b0}   // R2 back to run
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic c, input logic d);
        sleep_req  = s;
        refclk_run = c;
        deeper_n   = d;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        wait_neg(3);
        check("R1 level in reset", int'(state), 0);
        check("R1 pstat_n in reset", int'(pstat_n), 1);
        check("R1 vlow in reset", int'(vlow), 0);
        rst_n = 1'b1;
        wait_neg(SETTLE);
        check("R1 level after reset", int'(state), 0);

        // table walk
        for (int r = 0; r < 12; r++) begin
            drive(VEC[r][6], VEC[r][5], VEC[r][4]);
            wait_neg(SETTLE);
            check($sformatf("R%0d row %0d level", VEC[r][10:7], r), int'(state), int'(VEC[r][3:2]));
            check($sformatf("R%0d row %0d pstat_n", VEC[r][10:7], r), int'(pstat_n), int'(VEC[r][1]));
            check($sformatf("R%0d row %0d vlow", VEC[r][10:7], r), int'(vlow), int'(VEC[r][0]));
        end

        // R9 latency: level changes on the third edge after the input
        drive(1'b1, 1'b1, 1'b1);
        wait_neg(LAT - 1);
        check("R9 level before latency", int'(state), 0);
        wait_neg(1);
        check("R9 level at latency", int'(state), 1);

        // R4 chained entry: sleep seen first, then deeper next edge
        drive(1'b0, 1'b1, 1'b1);
        wait_neg(SETTLE);
        drive(1'b1, 1'b1, 1'b0);
        wait_neg(LAT);
        check("R4 passes through sleep", int'(state), 1);
        wait_neg(1);
        check("R4 deeper one edge later", int'(state), 3);
        check("R7 vlow in deeper", int'(vlow), 1);

        // R1 reset taken from deeper sleep
        rst_n = 1'b0;
        wait_neg(2);
        check("R1 level on reset from deeper", int'(state), 0);
        check("R1 pstat_n on reset from deeper", int'(pstat_n), 1);
        check("R1 vlow on reset from deeper", int'(vlow), 0);
        drive(1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        wait_neg(SETTLE);
        check("R8 idle after reset", int'(state), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule